// File: doc/BRIEF.md
# ADC DC Offset Remover with Estimate Freeze

This block takes signed 24-bit samples from an ADC decimation chain and removes their DC component. It keeps a running estimate of the offset in a leaky integrator and subtracts the integer part of that estimate from every incoming sample. The result is registered and saturated to the 24-bit range.

A freeze input stops the estimate from updating. The held value is still subtracted from every sample, so the filter stays in the path and is not bypassed. This is the setting to use for DC measurements after the offset has settled. When freeze is cleared, updating continues from the held value. The integrator time constant is set by a shift amount on a port, and the block clamps that amount to a legal window.

Top module: `dcr_top`

## Requirements
- R1: While rst_ni is low, valid_o and y_o are 0 and the estimate is cleared to 0. The first sample after reset therefore passes through unchanged.
- R2: Each cycle with valid_i high produces valid_o high in the next cycle. A cycle with valid_i low produces valid_o low in the next cycle.
- R3: For an accepted sample x, y_o equals x minus the estimate as it stood before that sample. The estimate is floor(acc / 2^FRAC_W), where acc is a signed accumulator of DATA_W+FRAC_W bits.
- R4: When valid_i is high and freeze_i is low, acc becomes acc + ((x*2^FRAC_W - acc) >>> K), using an arithmetic shift. A constant input therefore drives y_o toward zero.
- R5: When freeze_i is high, acc does not change, whatever the value of valid_i.
- R6: While freeze_i is high, the held estimate is still subtracted from every accepted sample.
- R7: y_o saturates to 8388607 or -8388608 when the difference is out of range. It never wraps.
- R8: K is shift_i clamped to the range K_MIN..K_MAX, which is 10..16 by default. A value below the range acts as 10 and a value above it acts as 16.
- R9: In a cycle with valid_i low, acc does not change and y_o keeps its value.
- R10: When freeze_i is cleared, updating continues from the held acc, with no reset or jump.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Input sample strobe |
| x_i | input | DATA_W | Signed input sample |
| freeze_i | input | 1 | Hold the DC estimate |
| shift_i | input | SH_W | Integrator shift K (clamped) |
| valid_o | output | 1 | Output sample strobe |
| y_o | output | DATA_W | Signed, saturated output sample |

## Verification
The bench uses the default parameters: DATA_W 24, FRAC_W 16 and a shift window of 10..16. With these values, about 12,000 samples at K=10 settle the estimate close to full scale. That puts both saturation limits within reach from a settled offset. It also allows checking that a DC step converges to a residual of only a few LSBs. The 5-bit shift port reaches values both below and above the window, so the clamping is exercised at each end.

// File: rtl/dcr_pkg.sv
package dcr_pkg;
  localparam int DCR_DATA_W = 24;
  localparam int DCR_FRAC_W = 16;
  localparam int DCR_K_MIN  = 10;
  localparam int DCR_K_MAX  = 16;
  localparam int DCR_SH_W   = 5;
endpackage

// File: rtl/dcr_estimator.sv
module dcr_estimator #(
  parameter  int DATA_W = 24,
  parameter  int FRAC_W = 16,
  parameter  int K_MIN  = 10,
  parameter  int K_MAX  = 16,
  parameter  int SH_W   = 5,
  localparam int ACC_W  = DATA_W + FRAC_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              upd_i,
  input  logic [DATA_W-1:0] x_i,
  input  logic [SH_W-1:0]   shift_i,
  output logic [ACC_W-1:0]  acc_o,
  output logic [DATA_W-1:0] est_o
);
  logic [ACC_W-1:0] acc_q;
  logic [SH_W-1:0]  sh;
  logic signed [ACC_W:0] x_ext, a_ext, err, step;

  always_comb begin
    if (shift_i < SH_W'(K_MIN))      sh = SH_W'(K_MIN);
    else if (shift_i > SH_W'(K_MAX)) sh = SH_W'(K_MAX);
    else                             sh = shift_i;
  end

  assign x_ext = $signed({x_i[DATA_W-1], x_i, {FRAC_W{1'b0}}});
  assign a_ext = $signed({acc_q[ACC_W-1], acc_q});
  assign err   = x_ext - a_ext;
  assign step  = err >>> sh;

  // acc stays a convex mix of scaled inputs, so truncation is safe
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    acc_q <= '0;
    else if (upd_i) acc_q <= acc_q + step[ACC_W-1:0];
  end

  assign acc_o = acc_q;
  assign est_o = acc_q[ACC_W-1:FRAC_W];
endmodule

// File: rtl/dcr_subsat.sv
module dcr_subsat #(
  parameter int DATA_W = 24
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] y_o
);
  localparam logic [DATA_W-1:0] MAX_V = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] MIN_V = {1'b1, {(DATA_W-1){1'b0}}};

  logic signed [DATA_W:0] diff;
  assign diff = $signed({a_i[DATA_W-1], a_i}) - $signed({b_i[DATA_W-1], b_i});

  always_comb begin
    if (diff[DATA_W] ^ diff[DATA_W-1]) y_o = diff[DATA_W] ? MIN_V : MAX_V;
    else                               y_o = diff[DATA_W-1:0];
  end
endmodule

// File: rtl/dcr_top.sv
module dcr_top
  import dcr_pkg::*;
#(
  parameter  int DATA_W = DCR_DATA_W,
  parameter  int FRAC_W = DCR_FRAC_W,
  parameter  int K_MIN  = DCR_K_MIN,
  parameter  int K_MAX  = DCR_K_MAX,
  parameter  int SH_W   = DCR_SH_W,
  localparam int ACC_W  = DATA_W + FRAC_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] x_i,
  input  logic              freeze_i,
  input  logic [SH_W-1:0]   shift_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] y_o
);
  logic [ACC_W-1:0]  acc_q;
  logic [DATA_W-1:0] est;
  logic [DATA_W-1:0] y_d;
  logic [DATA_W-1:0] y_q;
  logic              v_q;
  logic              upd;

  assign upd = valid_i & ~freeze_i;

  dcr_estimator #(
    .DATA_W(DATA_W), .FRAC_W(FRAC_W), .K_MIN(K_MIN), .K_MAX(K_MAX), .SH_W(SH_W)
  ) u_est (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .upd_i  (upd),
    .x_i    (x_i),
    .shift_i(shift_i),
    .acc_o  (acc_q),
    .est_o  (est)
  );

  dcr_subsat #(.DATA_W(DATA_W)) u_sub (
    .a_i(x_i),
    .b_i(est),
    .y_o(y_d)
  );

  // output uses the estimate before this sample's update
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q <= 1'b0;
      y_q <= '0;
    end else begin
      v_q <= valid_i;
      if (valid_i) y_q <= y_d;
    end
  end

  assign valid_o = v_q;
  assign y_o     = y_q;
endmodule

// File: rtl/dcr_checker.sv
module dcr_checker #(
  parameter int DATA_W = 24,
  parameter int ACC_W  = 40
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic              freeze_i,
  input logic [DATA_W-1:0] x_i,
  input logic [ACC_W-1:0]  acc_q,
  input logic [DATA_W-1:0] est_q,
  input logic              valid_o,
  input logic [DATA_W-1:0] y_o
);
  a_r2_valid_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  a_r2_idle_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  a_r5_frozen_acc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    freeze_i |=> $stable(acc_q));
  a_r9_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(acc_q) && $stable(y_o)));
  a_r7_no_wrap_pos: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !x_i[DATA_W-1] && est_q[DATA_W-1]) |=> !y_o[DATA_W-1]);
  a_r7_no_wrap_neg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && x_i[DATA_W-1] && !est_q[DATA_W-1] && (est_q != '0)) |=> y_o[DATA_W-1]);
endmodule

bind dcr_top dcr_checker #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .freeze_i(freeze_i),
  .x_i     (x_i),
  .acc_q   (acc_q),
  .est_q   (est),
  .valid_o (valid_o),
  .y_o     (y_o)
);

// File: tb/dcr_top_bench.sv
`timescale 1ns/1ps
module dcr_top_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [23:0] x_i = '0;
  logic        freeze_i = 1'b0;
  logic [4:0]  shift_i = 5'd10;
  logic        valid_o;
  logic [23:0] y_o;

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 1'b0;
  longint m_acc = 0;

  always #4 clk = ~clk;

  dcr_top u_dcr_top (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .x_i(x_i),
    .freeze_i(freeze_i), .shift_i(shift_i), .valid_o(valid_o), .y_o(y_o)
  );

  function automatic longint sat24(input longint v);
    if (v > 8388607)  return 8388607;
    if (v < -8388608) return -8388608;
    return v;
  endfunction

  function automatic int clampk(input int s);
    if (s < 10) return 10;
    if (s > 16) return 16;
    return s;
  endfunction

  function automatic longint ys();
    return longint'($signed(y_o));
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one accepted sample, checked against the model one cycle later
  task automatic send(input longint x, input bit frz, input int sh, input string tag);
    longint exp;
    @(negedge clk);
    valid_i  = 1'b1;
    x_i      = x[23:0];
    freeze_i = frz;
    shift_i  = sh[4:0];
    exp = sat24(x - (m_acc >>> 16));
    if (!frz) m_acc = m_acc + (((x <<< 16) - m_acc) >>> clampk(sh));
    @(posedge clk); #1;
    chk(valid_o === 1'b1, "R2 valid_o", longint'(valid_o), 1);
    chk(ys() == exp, tag, ys(), exp);
    @(negedge clk);
    valid_i = 1'b0;
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    m_acc = 0;
    repeat (3) @(posedge clk);
    #1;
    chk(valid_o === 1'b0, "R1 valid_o in reset", longint'(valid_o), 0);
    chk(y_o === 24'd0, "R1 y_o in reset", ys(), 0);
    @(negedge clk);
    rst_ni = 1'b1;
    send(12345, 1'b0, 10, "R1 first sample passes");
  endtask

  task automatic t_latency();
    send(-777, 1'b0, 10, "R3 subtract estimate");
    @(posedge clk); #1;
    chk(valid_o === 1'b0, "R2 valid_o drops", longint'(valid_o), 0);
  endtask

  task automatic t_converge();
    for (int i = 0; i < 12000; i++) send(100000, 1'b0, 10, "R4 dc step");
    chk(ys() < 64 && ys() > -64, "R4 converged near zero", ys(), 0);
  endtask

  task automatic t_freeze();
    longint y_ref;
    send(100000, 1'b1, 10, "R6 frozen subtract");
    y_ref = ys();
    for (int i = 0; i < 20; i++) send(-300000 + i * 1000, 1'b1, 10, "R6 held estimate subtracted");
    send(100000, 1'b1, 10, "R5 estimate unchanged");
    chk(ys() == y_ref, "R5 same input same output", ys(), y_ref);
  endtask

  task automatic t_release();
    for (int i = 0; i < 50; i++) send(-200000, 1'b0, 12, "R10 resume from held");
  endtask

  task automatic t_idle();
    longint y_ref;
    send(5000, 1'b0, 10, "R9 before idle");
    y_ref = ys();
    @(negedge clk);
    valid_i = 1'b0;
    x_i = 24'h7FFFFF;
    repeat (5) @(posedge clk);
    #1;
    chk(ys() == y_ref, "R9 y_o held while idle", ys(), y_ref);
    chk(valid_o === 1'b0, "R9 valid_o low while idle", longint'(valid_o), 0);
    send(5000, 1'b0, 10, "R9 estimate untouched by idle");
  endtask

  task automatic t_clamp();
    for (int i = 0; i < 40; i++) send(400000, 1'b0, 3, "R8 low clamp to 10");
    for (int i = 0; i < 40; i++) send(-400000, 1'b0, 31, "R8 high clamp to 16");
    for (int i = 0; i < 40; i++) send(250000, 1'b0, 13, "R8 in range shift");
  endtask

  task automatic t_saturate();
    for (int i = 0; i < 12000; i++) send(-8000000, 1'b0, 0, "R4 settle negative");
    send(8388607, 1'b1, 10, "R7 positive saturation");
    chk(ys() == 8388607, "R7 clipped high", ys(), 8388607);
    for (int i = 0; i < 14000; i++) send(8000000, 1'b0, 0, "R4 settle positive");
    send(-8388608, 1'b1, 10, "R7 negative saturation");
    chk(ys() == -8388608, "R7 clipped low", ys(), -8388608);
  endtask

  initial begin
    t_reset();
    t_latency();
    t_converge();
    t_freeze();
    t_release();
    t_idle();
    t_clamp();
    t_saturate();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule